// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the register bank of an Ethernet MAC DMA controller. Software reaches it over a 32-bit, word-indexed bus. Writes take effect on the clock edge, and reads return the addressed word combinationally. The bank holds the command word, the address-filter controls and the per-entry filter enable mask. It also holds the transmit and receive descriptor list bases, the current-descriptor words, a group of plain configuration words, an interrupt enable word and one interrupt status word. It drives these controls to the DMA engines and to the address filter, which are separate blocks.

The transmit and receive engines report events as single-cycle pulses on a 32-bit set vector. Each pulse sets the matching status bit. Status bits 31..16 hold transmit events and raise the transmit interrupt. Bits 15..0 hold receive events and raise the receive interrupt. Software acknowledges events by writing ones to the status word.

Writing bit 24 of the command word starts a soft reset that lasts a fixed number of cycles. During that time every read returns zero, and bus writes and event pulses are dropped. Software first waits for a non-zero register to read back and then for bit 24 to read clear.

Top module: `mcsr_top`

## Requirements
- R1: After the reset input is released, each word reads back its reset value. Word 5 (transmit list base) and word 6 (receive list base) read 0xFFFFFFFC. Word 9 (FIFO threshold) reads 0x00000101. Word 10 (receive frame-count limit) reads 0x00000800. Word 11 (missed-frame count) reads 0x00007FFF. Word 12 (management data-address) reads 0x00900000. Every other word reads 0.
- R2: Command word 0 keeps only bit 8 (transmit on), bit 1 (accept long frames) and bit 0 (receive on). These bits drive `tx_on`, `long_ok` and `rx_on`. Every other written bit reads back 0.
- R3: A pulse on `evt_set` sets the status bits of word 2 at the implemented positions only. The transmit positions are 24, 23, 18 and 16. The receive positions are 11, 10, 9, 8, 4, 3 and 0. All other bits of the pulse are ignored.
- R4: Writing a one to a bit of status word 2 clears that bit. Writing zeros leaves bits unchanged, so a write of 0xFFFF0000 clears only the transmit half.
- R5: When an event pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R6: `tx_irq` is high exactly when some bit in 31..16 is set in both status word 2 and enable word 1. `rx_irq` is the same for bits 15..0. Enable word 1 keeps only the implemented status positions.
- R7: Writing word 0 with bit 24 set starts a soft reset. `srst_busy` is high for exactly 8 cycles starting in the cycle after the write. After that, bit 24 of word 0 reads 0.
- R8: While `srst_busy` is high, every read returns 0, and bus writes and event pulses have no effect.
- R9: A soft reset returns every word to its R1 value. This includes the command word (so transmit and receive turn off), the current-descriptor words 7 and 8, and the status word.
- R10: The two low bits of the list bases (words 5 and 6) always read 0. Words 13 to 15 read 0, and writes to them change nothing.
- R11: Filter control word 3 keeps bit 4 (drives `cam_cmp_on`) and bit 0 (drives `ucast_all`). Word 4 holds one enable bit per filter entry, bits 15..0, and drives `cam_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word index for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| evt_set | input | 32 | Event pulses from the DMA engines |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| tx_on | output | 1 | Transmit enable |
| rx_on | output | 1 | Receive enable |
| long_ok | output | 1 | Accept long frames |
| cam_cmp_on | output | 1 | Address compare enable |
| ucast_all | output | 1 | Accept all unicast frames |
| cam_en | output | 16 | Per-entry filter enable |
| tx_list_base | output | 32 | Transmit descriptor list base |
| rx_list_base | output | 32 | Receive descriptor list base |
| srst_busy | output | 1 | Soft reset in progress |

## Verification
The bench applies all-ones writes and all-ones event pulses. These separate implemented bits from ignored ones in every word and in the status mask. Half-word clearing writes show whether the two status halves and their interrupt lines are kept apart. A same-cycle event-and-clear pattern shows whether the set takes priority. Writes and events issued during the soft-reset window expose any leak of state through the reset, and reads in that window expose any read that is not forced to zero. A long run of pseudo-random reads, writes and event pulses, with occasional soft resets, is then compared against a behavioural model on every cycle.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned A_CMD = 0;
  localparam int unsigned A_IEN = 1;
  localparam int unsigned A_IST = 2;
  localparam int unsigned A_FLT = 3;
  localparam int unsigned A_CAMEN = 4;
  localparam int unsigned A_TXB = 5;
  localparam int unsigned A_RXB = 6;

  localparam int unsigned SRST_BIT = 24;
  localparam logic [DW-1:0] IST_MASK = 32'h0185_0F19;
  localparam logic [DW-1:0] CMD_KEEP = 32'h0000_0103;
  localparam logic [DW-1:0] FLT_KEEP = 32'h0000_0011;
  localparam logic [DW-1:0] BASE_KEEP = 32'hFFFF_FFFC;

  // Storage words other than the status word, in slot order.
  localparam int unsigned NPLAIN = 12;

  function automatic int unsigned slot_addr(input int unsigned s);
    return (s < 2) ? s : s + 1;
  endfunction

  function automatic logic [DW-1:0] slot_keep(input int unsigned s,
                                              input logic [DW-1:0] cam_mask);
    case (s)
      0: return CMD_KEEP;
      1: return IST_MASK;
      2: return FLT_KEEP;
      3: return cam_mask;
      4, 5: return BASE_KEEP;
      default: return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_rst(input int unsigned s);
    case (s)
      4, 5: return 32'hFFFF_FFFC;
      8: return 32'h0000_0101;
      9: return 32'h0000_0800;
      10: return 32'h0000_7FFF;
      11: return 32'h0090_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mcsr_cfg_reg.sv
module mcsr_cfg_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] KEEP = '1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | we;
    q_d  = clr ? RSTV : (wdata & KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RSTV;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/mcsr_srst_seq.sv
module mcsr_srst_seq #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mcsr_status.sv
module mcsr_status #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt_ok,
  input  logic         w1c_en,
  input  logic [W-1:0] w1c_data,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ien,
  output logic [W-1:0] ist_q,
  output logic         tx_irq,
  output logic         rx_irq
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] ist_d, clr_bits, set_bits, act;

  always_comb begin
    clr_bits = w1c_en ? w1c_data : '0;
    set_bits = evt_ok ? (evt & MASK) : '0;
    ist_d    = clr ? '0 : ((ist_q & ~clr_bits) | set_bits);
    act      = ist_q & ien;
    tx_irq   = |act[W-1:H];
    rx_irq   = |act[H-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ist_q <= '0;
    else        ist_q <= ist_d;
  end
endmodule

// File: rtl/mcsr_top.sv
module mcsr_top
  import mcsr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned NUM_CAM     = 16,
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [DW-1:0]      evt_set,
  output logic               tx_irq,
  output logic               rx_irq,
  output logic               tx_on,
  output logic               rx_on,
  output logic               long_ok,
  output logic               cam_cmp_on,
  output logic               ucast_all,
  output logic [NUM_CAM-1:0] cam_en,
  output logic [DW-1:0]      tx_list_base,
  output logic [DW-1:0]      rx_list_base,
  output logic               srst_busy
);
  localparam logic [DW-1:0] CAM_MASK = DW'((64'd1 << NUM_CAM) - 1);

  logic          srst_start, wr_ok;
  logic [DW-1:0] plain_q [NPLAIN];
  logic [DW-1:0] ist_q;

  always_comb begin
    wr_ok      = bus_wr & ~srst_busy;
    srst_start = wr_ok & (bus_addr == ADDR_W'(A_CMD)) & bus_wdata[SRST_BIT];
  end

  mcsr_srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy)
  );

  for (genvar g = 0; g < NPLAIN; g++) begin : g_word
    logic we_g;
    assign we_g = wr_ok & (bus_addr == ADDR_W'(slot_addr(g)));
    mcsr_cfg_reg #(
      .W    (DW),
      .KEEP (slot_keep(g, CAM_MASK)),
      .RSTV (slot_rst(g))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst_start),
      .we    (we_g),
      .wdata (bus_wdata),
      .q     (plain_q[g])
    );
  end

  mcsr_status #(.W(DW), .MASK(IST_MASK)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (srst_start),
    .evt_ok   (~srst_busy),
    .w1c_en   (wr_ok & (bus_addr == ADDR_W'(A_IST))),
    .w1c_data (bus_wdata),
    .evt      (evt_set),
    .ien      (plain_q[1]),
    .ist_q    (ist_q),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_IST)) bus_rdata = ist_q;
    for (int s = 0; s < NPLAIN; s++) begin
      if (bus_addr == ADDR_W'(slot_addr(s))) bus_rdata = plain_q[s];
    end
    if (srst_busy) bus_rdata = '0;
  end

  assign tx_on        = plain_q[0][8];
  assign long_ok      = plain_q[0][1];
  assign rx_on        = plain_q[0][0];
  assign cam_cmp_on   = plain_q[2][4];
  assign ucast_all    = plain_q[2][0];
  assign cam_en       = plain_q[3][NUM_CAM-1:0];
  assign tx_list_base = plain_q[4];
  assign rx_list_base = plain_q[5];
endmodule

// File: rtl/mcsr_chk.sv
module mcsr_chk
  import mcsr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SRST_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     evt_set,
  input logic [DW-1:0]     bus_rdata,
  input logic              tx_irq,
  input logic              tx_on,
  input logic              rx_on,
  input logic              busy,
  input logic [DW-1:0]     ist
);
  logic [15:0] run_len;
  logic        start_w;

  assign start_w = bus_wr && (bus_addr == ADDR_W'(A_CMD)) && bus_wdata[SRST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_rdata == '0); // R8

  AST_SRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == 16'(SRST_CYCLES)); // R7

  AST_CMD_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!tx_on && !rx_on && ist == '0)); // R9

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_wr && bus_addr == ADDR_W'(A_IST) && evt_set == '0)
      |=> (ist & $past(bus_wdata)) == '0); // R4

  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_w && (evt_set & IST_MASK) != '0)
      |=> (ist & $past(evt_set & IST_MASK)) == $past(evt_set & IST_MASK)); // R5

  AST_TX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> ($past(bus_wr) || $past(evt_set[31:16]) != '0)); // R6
endmodule

bind mcsr_top mcsr_chk #(.ADDR_W(ADDR_W), .SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .evt_set   (evt_set),
  .bus_rdata (bus_rdata),
  .tx_irq    (tx_irq),
  .tx_on     (tx_on),
  .rx_on     (rx_on),
  .busy      (srst_busy),
  .ist       (ist_q)
);

// File: tb/tb_mcsr_top.sv
`timescale 1ns/1ps
module tb_mcsr_top;
  logic        clk, rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata, bus_rdata, evt_set, tx_list_base, rx_list_base;
  logic        tx_irq, rx_irq, tx_on, rx_on, long_ok, cam_cmp_on, ucast_all, srst_busy;
  logic [15:0] cam_en;

  mcsr_top dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [31:0] mr [16];
  bit mbusy;
  int mcnt;

  function automatic void mreset();
    for (int i = 0; i < 16; i++) mr[i] = 32'h0;
    mr[5] = 32'hFFFF_FFFC; mr[6] = 32'hFFFF_FFFC; mr[9] = 32'h101;
    mr[10] = 32'h800; mr[11] = 32'h7FFF; mr[12] = 32'h0090_0000;
  endfunction

  function automatic logic [31:0] mread(input logic [3:0] a);
    if (mbusy || a > 12) return 32'h0;
    return mr[a];
  endfunction

  function automatic void mupdate(input logic [3:0] a, input logic w,
                                  input logic [31:0] d, input logic [31:0] e);
    logic [31:0] nist;
    if (mbusy) begin
      mcnt--;
      if (mcnt == 0) mbusy = 1'b0;
      return;
    end
    if (w && a == 0 && d[24]) begin
      mreset(); mbusy = 1'b1; mcnt = 8;
      return;
    end
    nist = mr[2];
    if (w && a == 2) nist = nist & ~d;
    nist = nist | (e & 32'h0185_0F19);
    if (w) begin
      case (a)
        0: mr[0] = d & 32'h103;
        1: mr[1] = d & 32'h0185_0F19;
        3: mr[3] = d & 32'h11;
        4: mr[4] = d & 32'hFFFF;
        5, 6: mr[a] = d & 32'hFFFF_FFFC;
        7, 8, 9, 10, 11, 12: mr[a] = d;
        default: ;
      endcase
    end
    mr[2] = nist;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [31:0] t = mr[2] & mr[1];
    chk("rdata", bus_rdata, mread(bus_addr));
    chk("tx_irq", 32'(tx_irq), 32'(|t[31:16]));
    chk("rx_irq", 32'(rx_irq), 32'(|t[15:0]));
    chk("tx_on", 32'(tx_on), 32'(mr[0][8]));
    chk("rx_on", 32'(rx_on), 32'(mr[0][0]));
    chk("long_ok", 32'(long_ok), 32'(mr[0][1]));
    chk("cam_cmp_on", 32'(cam_cmp_on), 32'(mr[3][4]));
    chk("ucast_all", 32'(ucast_all), 32'(mr[3][0]));
    chk("cam_en", 32'(cam_en), mr[4] & 32'hFFFF);
    chk("tx_list_base", tx_list_base, mr[5]);
    chk("rx_list_base", rx_list_base, mr[6]);
    chk("srst_busy", 32'(srst_busy), 32'(mbusy));
  endtask

  task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d,
                      input logic [31:0] e);
    bus_addr = a; bus_wr = w; bus_wdata = d; evt_set = e;
    #1 compare();
    @(posedge clk);
    mupdate(a, w, d, e);
    @(negedge clk);
  endtask

  task automatic read_all();
    for (int i = 0; i < 16; i++) step(4'(i), 1'b0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; evt_set = '0;
    mreset(); mbusy = 1'b0; mcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1"; read_all();
    cur_req = "R2";
    step(0, 1, 32'hFEFF_FFFF, 0); step(0, 0, 0, 0);
    step(0, 1, 32'h0000_0100, 0); step(0, 0, 0, 0);
    cur_req = "R11";
    step(3, 1, 32'hFFFF_FFFF, 0); step(4, 1, 32'hFFFF_FFFF, 0);
    step(3, 0, 0, 0); step(4, 0, 0, 0);
    step(4, 1, 32'h0000_8001, 0); step(4, 0, 0, 0);
    cur_req = "R10";
    step(5, 1, 32'h1234_5677, 0); step(6, 1, 32'hFFFF_FFFF, 0);
    step(5, 0, 0, 0); step(14, 1, 32'hDEAD_BEEF, 0); step(14, 0, 0, 0);
    cur_req = "R3";
    step(2, 0, 0, 32'hFFFF_FFFF); step(2, 0, 0, 0);
    cur_req = "R6";
    step(1, 1, 32'hFFFF_FFFF, 0); step(1, 0, 0, 0);
    step(1, 1, 32'h0001_0000, 0); step(2, 0, 0, 0);
    cur_req = "R4";
    step(2, 1, 32'hFFFF_0000, 0); step(2, 0, 0, 0);
    step(1, 1, 32'h0000_0010, 0); step(2, 0, 0, 0);
    step(2, 1, 32'h0000_FFFF, 0); step(2, 0, 0, 0);
    cur_req = "R5";
    step(2, 1, 32'h0000_0010, 32'h0000_0010); step(2, 0, 0, 0);
    step(2, 1, 32'h0180_0000, 32'h0100_0000); step(2, 0, 0, 0);
    cur_req = "R7";
    step(7, 1, 32'h5555_AAAA, 0); step(0, 1, 32'h0000_0103, 0);
    step(0, 1, 32'h0100_0103, 32'h0000_0001);
    cur_req = "R8";
    for (int i = 0; i < 8; i++) step(4'(i), 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    cur_req = "R9"; read_all();

    cur_req = "R3/R4 mixed";
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      d = {lfsr[15:0], lfsr[31:16]};
      if (lfsr[7:0] == 8'h5A) step(0, 1'b1, 32'h0100_0000, 32'h0);
      else step(lfsr[3:0] & 4'hF, lfsr[4] & lfsr[5],
                (lfsr[8] ? d & ~32'h0100_0000 : d), (lfsr[9] & lfsr[10]) ? ~d : 32'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule